// File: doc/BRIEF.md
# Programmable-Size Base Address Register

This block is one configuration-space base address register that can occupy one or two words, plus a setup register that decides how much of it software may change. The setup register holds a log2 size value and an enable flag. The size value decides which stored base bits can be written. A size of zero opens every bit. A size of four or more opens the bits at and above that address position. A size of one to three closes every bit. The space kind (32-bit memory, 64-bit memory or I/O) is fixed by a parameter, and only the 64-bit memory kind has an upper base word.

Software reaches the registers through a plain 32-bit configuration port with an address, a write strobe, byte enables, write data and combinational read data. Separately from that port, the block compares a 64-bit transaction address against the stored base and raises a hit flag when the address falls inside the window. The stored base starts at address bit 4. Address bits 3:0 are never stored and never compared.

Top module: `bar_prog_size`

## Requirements
- R1: The setup register sits at offset SETUP_OFS. It holds the size value in bits 9:4 and the enable flag in bit 31. Bits 3:0 and 30:10 read as zero and ignore writes. Each byte of a write lands only where its byte enable is set: byte 0 carries size bits 3:0, byte 1 carries size bits 5:4, and byte 3 carries the enable.
- R2: The low base word sits at BAR_OFS. While enabled, its bits 31:4 show stored address bits 31:4, and bits 3:0 show the kind code: 4'b0000 for 32-bit memory, 4'b0100 for 64-bit memory, 4'b0001 for I/O. Any other offset reads zero.
- R3: With size zero, every stored bit can be written: address bits 63:4 for the 64-bit kind, and 31:4 otherwise.
- R4: With a size of 4 or more, address bits at or above the size value can be written. Bits from 4 up to size minus one read as zero and ignore writes.
- R5: A size of 1, 2 or 3 makes every stored bit read-only zero, and the hit flag stays low.
- R6: The 32-bit kinds have no upper word: offset BAR_OFS+4 reads zero, and a size above 32 leaves every low-word base bit at zero. Only the 64-bit kind stores address bits 63:32, in the word at BAR_OFS+4.
- R7: While the enable flag is clear, both base words read zero (kind code included), writes to them have no effect, and the hit flag stays low.
- R8: Any setup write that makes stored bits read-only (a larger size, an invalid size or a cleared enable) clears those bits at the same clock edge. Making them writable again later still reads zero.
- R9: The hit flag is high when the block is enabled, the size is valid, and the transaction address equals the stored base at every writable position. For the 32-bit kinds, transaction address bits 63:32 must also be zero.
- R10: A synchronous active-low reset clears the size, the enable and the stored base, so every register reads zero.
- R11: Small sizes are not policed. A memory-kind register accepts a size of 4 and then decodes a 16-byte window.
- R12: Base word writes honour byte enables. Only the bytes whose enables are set change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_addr | input | CFG_AW | Configuration byte offset for reads and writes |
| cfg_we | input | 1 | Write strobe, one cycle per write |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr, combinational |
| hit_addr | input | 64 | Transaction address to decode |
| hit | output | 1 | Transaction address falls inside the window |

## Verification
The bench builds two copies side by side on the same configuration bus. One uses the 64-bit memory kind and the other the I/O kind, both with the default offsets. Because every write reaches both, the same size value shows its different effect on each. A size of 40 opens part of the upper word on the 64-bit copy and clears the whole low word on the I/O copy, and the upper-zero hit condition can only be seen on the 32-bit copy. Both kind codes also appear on read-back.

// File: rtl/bar_pkg.sv
package bar_pkg;

  typedef enum logic [1:0] {
    KIND_MEM32 = 2'd0,
    KIND_MEM64 = 2'd1,
    KIND_IO    = 2'd2
  } bar_kind_e;

  localparam int ADDR_W   = 64;
  localparam int ADDR_LSB = 4;
  localparam int BASE_W   = ADDR_W - ADDR_LSB;
  localparam int DATA_W   = 32;
  localparam int SIZE_W   = 6;
  localparam int SIZE_LSB = 4;
  localparam int EN_BIT   = 31;
  localparam int LO_BITS  = DATA_W - ADDR_LSB;

  // Writable stored-base positions for a given setup; bit i covers address bit i+4.
  function automatic logic [BASE_W-1:0] wr_mask(input logic en,
                                                input logic [SIZE_W-1:0] size,
                                                input logic is64);
    logic [BASE_W-1:0] m;
    for (int i = 0; i < BASE_W; i++) begin
      int pos;
      pos = i + ADDR_LSB;
      m[i] = en && (is64 || pos < DATA_W) &&
             ((size == '0) || (int'(size) >= ADDR_LSB && pos >= int'(size)));
    end
    return m;
  endfunction

  function automatic logic size_valid(input logic [SIZE_W-1:0] size);
    return (size == '0) || (int'(size) >= ADDR_LSB);
  endfunction

  function automatic logic [ADDR_LSB-1:0] kind_code(input bar_kind_e k);
    case (k)
      KIND_MEM64: return 4'b0100;
      KIND_IO:    return 4'b0001;
      default:    return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/bar_setup_reg.sv
module bar_setup_reg
  import bar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3:0]        be,
  input  logic [DATA_W-1:0] wdata,
  output logic [SIZE_W-1:0] size_q,
  output logic              en_q,
  output logic [SIZE_W-1:0] size_d,
  output logic              en_d
);

  logic unused_bits;
  assign unused_bits = ^{wdata[30:10], wdata[3:0], be[2]};

  always_comb begin
    size_d = size_q;
    en_d   = en_q;
    if (wr && be[0]) size_d[3:0] = wdata[SIZE_LSB +: 4];
    if (wr && be[1]) size_d[5:4] = wdata[SIZE_LSB+4 +: 2];
    if (wr && be[3]) en_d        = wdata[EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      en_q   <= 1'b0;
    end else begin
      size_q <= size_d;
      en_q   <= en_d;
    end
  end

endmodule

// File: rtl/bar_base_reg.sv
module bar_base_reg
  import bar_pkg::*;
#(
  parameter bit IS64 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [3:0]        be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BASE_W-1:0] keep_mask,
  output logic [BASE_W-1:0] base_q
);

  logic [DATA_W-1:0]  byte_mask;
  logic [LO_BITS-1:0] lo_d;
  logic [DATA_W-1:0]  hi_d;
  logic [BASE_W-1:0]  base_d;

  for (genvar b = 0; b < 4; b++) begin : g_bm
    assign byte_mask[b*8 +: 8] = {8{be[b]}};
  end

  assign lo_d = wr_lo ? ((base_q[LO_BITS-1:0] & ~byte_mask[DATA_W-1:ADDR_LSB]) |
                         (wdata[DATA_W-1:ADDR_LSB] & byte_mask[DATA_W-1:ADDR_LSB]))
                      : base_q[LO_BITS-1:0];

  if (IS64) begin : g_hi
    assign hi_d = wr_hi ? ((base_q[BASE_W-1:LO_BITS] & ~byte_mask) | (wdata & byte_mask))
                        : base_q[BASE_W-1:LO_BITS];
  end else begin : g_no_hi
    logic unused_hi;
    assign unused_hi = ^{wr_hi, wdata[ADDR_LSB-1:0], base_q[BASE_W-1:LO_BITS]};
    assign hi_d = '0;
  end

  // Apply the mask of the setup that takes effect at this edge.
  assign base_d = {hi_d, lo_d} & keep_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

endmodule

// File: rtl/bar_hit_cmp.sv
module bar_hit_cmp
  import bar_pkg::*;
#(
  parameter bit IS64 = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic [BASE_W-1:0] mask,
  input  logic              en,
  input  logic              size_ok,
  output logic              hit
);

  logic unused_lsb;
  logic span_ok;
  logic base_eq;

  assign unused_lsb = ^addr[ADDR_LSB-1:0];
  assign base_eq    = ((addr[ADDR_W-1:ADDR_LSB] ^ base) & mask) == '0;

  if (IS64) begin : g_wide
    assign span_ok = 1'b1;
  end else begin : g_narrow
    assign span_ok = addr[ADDR_W-1:DATA_W] == '0;
  end

  assign hit = en && size_ok && base_eq && span_ok;

endmodule

// File: rtl/bar_prog_size.sv
module bar_prog_size
  import bar_pkg::*;
#(
  parameter int unsigned CFG_AW    = 12,
  parameter int unsigned SETUP_OFS = 'h0A0,
  parameter int unsigned BAR_OFS   = 'h010,
  parameter bar_kind_e   KIND      = KIND_MEM64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [63:0]       hit_addr,
  output logic              hit
);

  localparam bit                IS64    = (KIND == KIND_MEM64);
  localparam logic [CFG_AW-1:0] SETUP_A = CFG_AW'(SETUP_OFS);
  localparam logic [CFG_AW-1:0] LO_A    = CFG_AW'(BAR_OFS);
  localparam logic [CFG_AW-1:0] HI_A    = CFG_AW'(BAR_OFS + 4);

  // Named events and state for the checker.
  logic              sel_setup, sel_lo, sel_hi;
  logic              wr_setup, wr_lo, wr_hi;
  logic [SIZE_W-1:0] size_q, size_d;
  logic              en_q, en_d;
  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] cur_mask, nxt_mask;
  logic              size_ok;

  assign sel_setup = cfg_addr == SETUP_A;
  assign sel_lo    = cfg_addr == LO_A;
  assign sel_hi    = IS64 && (cfg_addr == HI_A);
  assign wr_setup  = cfg_we && sel_setup;
  assign wr_lo     = cfg_we && sel_lo && en_q;
  assign wr_hi     = cfg_we && sel_hi && en_q;

  bar_setup_reg u_setup (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_setup),
    .be     (cfg_be),
    .wdata  (cfg_wdata),
    .size_q (size_q),
    .en_q   (en_q),
    .size_d (size_d),
    .en_d   (en_d)
  );

  assign nxt_mask = wr_mask(en_d, size_d, IS64);
  assign cur_mask = wr_mask(en_q, size_q, IS64);
  assign size_ok  = size_valid(size_q);

  bar_base_reg #(.IS64(IS64)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .be        (cfg_be),
    .wdata     (cfg_wdata),
    .keep_mask (nxt_mask),
    .base_q    (base_q)
  );

  bar_hit_cmp #(.IS64(IS64)) u_hit (
    .addr    (hit_addr),
    .base    (base_q),
    .mask    (cur_mask),
    .en      (en_q),
    .size_ok (size_ok),
    .hit     (hit)
  );

  always_comb begin
    cfg_rdata = '0;
    if (sel_setup) begin
      cfg_rdata[EN_BIT]             = en_q;
      cfg_rdata[SIZE_LSB +: SIZE_W] = size_q;
    end else if (sel_lo && en_q) begin
      cfg_rdata = {base_q[LO_BITS-1:0], kind_code(KIND)};
    end else if (sel_hi && en_q) begin
      cfg_rdata = base_q[BASE_W-1:LO_BITS];
    end
  end

endmodule

// File: rtl/bar_prog_size_chk.sv
module bar_prog_size_chk
  import bar_pkg::*;
#(
  parameter int unsigned CFG_AW    = 12,
  parameter int unsigned SETUP_OFS = 'h0A0,
  parameter int unsigned BAR_OFS   = 'h010,
  parameter bit          IS64      = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic [63:0]       hit_addr,
  input logic              hit,
  input logic              en_q,
  input logic              size_ok,
  input logic [BASE_W-1:0] base_q,
  input logic [BASE_W-1:0] cur_mask
);

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == CFG_AW'(SETUP_OFS)) |-> (cfg_rdata[3:0] == '0 && cfg_rdata[30:10] == '0));

  assert_bad_size_no_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !size_ok |-> !hit);

  assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS64 && hit) |-> (hit_addr[63:32] == '0));

  assert_off_no_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !hit);

  assert_off_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && cfg_addr == CFG_AW'(BAR_OFS)) |-> (cfg_rdata == '0));

  assert_ro_bits_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q & ~cur_mask) == '0);

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> (base_q == '0));

  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |=> (!en_q && base_q == '0));

endmodule

bind bar_prog_size bar_prog_size_chk #(
  .CFG_AW    (CFG_AW),
  .SETUP_OFS (SETUP_OFS),
  .BAR_OFS   (BAR_OFS),
  .IS64      (IS64)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_addr  (cfg_addr),
  .cfg_rdata (cfg_rdata),
  .hit_addr  (hit_addr),
  .hit       (hit),
  .en_q      (en_q),
  .size_ok   (size_ok),
  .base_q    (base_q),
  .cur_mask  (cur_mask)
);

// File: tb/test_bar_prog_size.sv
module test_bar_prog_size;
  import bar_pkg::*;

  localparam logic [11:0] SETUP = 12'h0A0;
  localparam logic [11:0] BLO   = 12'h010;
  localparam logic [11:0] BHI   = 12'h014;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [63:0] hit_addr = '0;
  logic [31:0] rd64, rdio;
  logic        hit64, hitio;

  always #10 clk = ~clk;

  bar_prog_size #(.KIND(KIND_MEM64)) i_bar_prog_size (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd64), .hit_addr(hit_addr), .hit(hit64));

  bar_prog_size #(.KIND(KIND_IO)) i_bar_prog_size_io (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdio), .hit_addr(hit_addr), .hit(hitio));

  int n_chk = 0;
  int n_fail = 0;
  bit live = 0;
  bit done = 0;

  // Reference model: index 0 = 64-bit memory copy, index 1 = I/O copy.
  int          m_size [2];
  bit          m_en   [2];
  logic [63:0] m_base [2];

  function automatic bit open_bit(int k, int p);
    if (!m_en[k]) return 0;
    if (k == 1 && p >= 32) return 0;
    if (m_size[k] == 0) return 1;
    if (m_size[k] < 4) return 0;
    return p >= m_size[k];
  endfunction

  function automatic logic [31:0] m_read(int k, logic [11:0] a);
    if (a == SETUP) return {m_en[k], 21'd0, 6'(m_size[k]), 4'd0};
    if (a == BLO && m_en[k]) return {m_base[k][31:4], (k == 0) ? 4'b0100 : 4'b0001};
    if (a == BHI && m_en[k] && k == 0) return m_base[k][63:32];
    return 32'd0;
  endfunction

  function automatic bit m_hit(int k, logic [63:0] a);
    if (!m_en[k] || (m_size[k] != 0 && m_size[k] < 4)) return 0;
    for (int p = 4; p < 64; p++) begin
      if (k == 1 && p >= 32) begin
        if (a[p]) return 0;
      end else if (open_bit(k, p) && a[p] != m_base[k][p]) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    live = 1;
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_size[k] = 0; m_en[k] = 0; m_base[k] = '0;
      end else if (cfg_we) begin
        if (cfg_addr == SETUP) begin
          if (cfg_be[0]) m_size[k] = (m_size[k] & 'h30) | int'(cfg_wdata[7:4]);
          if (cfg_be[1]) m_size[k] = (m_size[k] & 'h0F) | (int'(cfg_wdata[9:8]) * 16);
          if (cfg_be[3]) m_en[k] = cfg_wdata[31];
        end
        for (int b = 0; b < 4; b++)
          for (int j = 0; j < 8; j++) begin
            if (cfg_be[b] && cfg_addr == BLO && (b*8+j) >= 4 && open_bit(k, b*8+j))
              m_base[k][b*8+j] = cfg_wdata[b*8+j];
            if (cfg_be[b] && cfg_addr == BHI && open_bit(k, 32+b*8+j))
              m_base[k][32+b*8+j] = cfg_wdata[b*8+j];
          end
        for (int p = 0; p < 64; p++)
          if (p < 4 || !open_bit(k, p)) m_base[k][p] = 1'b0;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) begin
    if (live && rst_n && !done) begin
      chk("R2 readback 64", rd64, m_read(0, cfg_addr));
      chk("R2 readback io", rdio, m_read(1, cfg_addr));
      chk("R9 hit 64", hit64, m_hit(0, hit_addr));
      chk("R9 hit io", hitio, m_hit(1, hit_addr));
    end
  end

  task automatic wr(logic [11:0] a, logic [3:0] be, logic [31:0] d);
    @(posedge clk); #2;
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); #2;
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(logic [11:0] a);
    cfg_addr = a;
    #5;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R10 reset state
    rd(SETUP); chk("R10 setup", rd64, 32'h0);
    rd(BLO);   chk("R10 lo 64", rd64, 32'h0); chk("R10 lo io", rdio, 32'h0);
    rd(BHI);   chk("R10 hi", rd64, 32'h0);

    // R3 full space, R6 upper word only on 64-bit kind
    wr(SETUP, 4'hF, 32'h8000_0000);
    wr(BLO, 4'hF, 32'hFFFF_FFFF);
    wr(BHI, 4'hF, 32'hFFFF_FFFF);
    rd(BLO); chk("R3 lo 64", rd64, 32'hFFFF_FFF4); chk("R3 lo io", rdio, 32'hFFFF_FFF1);
    rd(BHI); chk("R3 hi 64", rd64, 32'hFFFF_FFFF); chk("R6 hi io", rdio, 32'h0);

    // R4 size 12; R8 bits stay cleared after widening
    wr(SETUP, 4'hF, 32'h8000_00C0);
    rd(BLO); chk("R4 lo 64", rd64, 32'hFFFF_F004); chk("R4 lo io", rdio, 32'hFFFF_F001);
    wr(SETUP, 4'hF, 32'h8000_0000);
    rd(BLO); chk("R8 lo 64", rd64, 32'hFFFF_F004);

    // R1 reserved bits ignored
    wr(SETUP, 4'hF, 32'hFFFF_FCCF);
    rd(SETUP); chk("R1 setup", rd64, 32'h8000_00C0);

    // R1 byte enables; R5 size 1 disables
    wr(SETUP, 4'b0001, 32'h0000_0010);
    rd(SETUP); chk("R1 byte0 only", rd64, 32'h8000_0010);
    hit_addr = 64'h0;
    rd(BLO); chk("R5 lo 64", rd64, 32'h0000_0004); chk("R5 lo io", rdio, 32'h0000_0001);
    chk("R5 hit 64", hit64, 0); chk("R5 hit io", hitio, 0);

    // R11 size 4 accepted
    wr(SETUP, 4'hF, 32'h8000_0040);
    wr(BLO, 4'hF, 32'h1234_5678);
    rd(BLO); chk("R11 lo 64", rd64, 32'h1234_5674); chk("R11 lo io", rdio, 32'h1234_5671);
    rd(BHI); chk("R8 hi cleared", rd64, 32'h0);
    hit_addr = 64'h1234_567C; #2;
    chk("R9 in 64", hit64, 1); chk("R9 in io", hitio, 1);
    hit_addr = 64'h1234_5680; #2;
    chk("R9 out 64", hit64, 0); chk("R9 out io", hitio, 0);

    // R12 byte enables on base writes
    wr(BLO, 4'b1000, 32'hAB00_0000);
    wr(BLO, 4'b0001, 32'h0000_00FF);
    rd(BLO); chk("R12 lo 64", rd64, 32'hAB34_56F4);

    // R9 / R6 upper address bits
    hit_addr = 64'h1_AB34_56F0; #2;
    chk("R9 upper 64", hit64, 0); chk("R6 upper io", hitio, 0);
    hit_addr = 64'h0_AB34_56F0; #2;
    chk("R9 match 64", hit64, 1); chk("R9 match io", hitio, 1);

    // R6 size 40
    wr(BHI, 4'hF, 32'hFFFF_FFFF);
    wr(SETUP, 4'hF, 32'h8000_0280);
    rd(BLO); chk("R4 lo 64 s40", rd64, 32'h0000_0004); chk("R6 lo io s40", rdio, 32'h0000_0001);
    rd(BHI); chk("R4 hi 64 s40", rd64, 32'hFFFF_FF00);
    hit_addr = 64'h0000_0000_DEAD_BEE0; #2;
    chk("R9 low 64", hit64, 0); chk("R6 low io", hitio, 1);
    hit_addr = 64'hFFFF_FF12_3456_7890; #2;
    chk("R9 high 64", hit64, 1); chk("R6 high io", hitio, 0);

    // R7 disable
    wr(SETUP, 4'hF, 32'h0000_0280);
    rd(BLO); chk("R7 lo 64", rd64, 32'h0); chk("R7 lo io", rdio, 32'h0);
    rd(BHI); chk("R7 hi 64", rd64, 32'h0);
    chk("R7 hit 64", hit64, 0);
    wr(BLO, 4'hF, 32'hFFFF_FFFF);
    wr(SETUP, 4'hF, 32'h8000_0000);
    rd(BLO); chk("R7 lo 64 after", rd64, 32'h0000_0004); chk("R7 lo io after", rdio, 32'h0000_0001);
    rd(BHI); chk("R8 hi 64 after", rd64, 32'h0);

    @(posedge clk); #2;
    finish_run();
  end

endmodule